// File: doc/BRIEF.md
# Mode-Steered Internal Data Memory Decoder

This block sits between a small CPU's internal data-space request port and three physical targets: a 128-byte lower RAM, a 128-byte upper RAM, and a special function register (SFR) space served by logic outside the block. Each request carries an 8-bit address, a write flag, write data and a flag that says whether the instruction used direct or indirect addressing. Requests below 80H always reach the lower RAM. Requests from 80H to FFH are steered by the addressing mode. An indirect access reaches the upper RAM. A direct access reaches the SFR port.

The upper RAM and the SFR space overlap in address but hold separate storage. A direct write to A0H updates the SFR at A0H, for example a port register. An indirect write through a pointer holding A0H updates upper-RAM byte A0H, and neither write touches the other target. The SFR port issues a one-cycle strobe carrying the address, data and write flag. The outside logic answers with read data and a hit flag in that same cycle. Every request receives one response in the next cycle. A direct access to an SFR address that the outside logic does not claim is reported as an error.

Top module: `idm_router`

## Requirements
- R1: Requests with address 00H–7FH reach the lower RAM whatever the mode flag says. A byte written with one mode reads back with either mode.
- R2: An indirect request (`req_indirect`=1) with address 80H–FFH reaches the upper RAM and never raises `sfr_stb`.
- R3: A direct request (`req_indirect`=0) with address 80H–FFH raises `sfr_stb` in the request cycle only, with `sfr_addr`, `sfr_we` and `sfr_wdata` equal to the request's address, write flag and data. A direct read returns the `sfr_rdata` value sampled in that cycle.
- R4: The upper RAM and the SFR space are separate. A direct write to an address in 80H–FFH leaves the upper-RAM byte at that address unchanged. An indirect write never reaches the SFR port.
- R5: Each accepted request (`req_valid`=1 at a rising edge) yields `rsp_valid`=1 in exactly the next cycle, and `rsp_valid` is 0 after a cycle with no request.
- R6: A direct request to 80H–FFH while `sfr_hit`=0 gives `rsp_err`=1 and `rsp_rdata`=00H in its response cycle. All other requests give `rsp_err`=0.
- R7: While `rst_n` is low, `sfr_stb` stays 0. After reset, `rsp_valid` and `rsp_err` are 0 until the first request.
- R8: The response to a write request carries `rsp_rdata`=00H.
- R9: Requests to 00H–7FH never raise `sfr_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = indirect addressing, 0 = direct |
| req_addr | input | 8 | Data-space address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 8 | Read data (00H for writes and errors) |
| rsp_err | output | 1 | Unclaimed SFR access |
| sfr_stb | output | 1 | SFR access strobe, request cycle only |
| sfr_we | output | 1 | SFR write flag |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, same cycle as the strobe |
| sfr_hit | input | 1 | Outside logic claims the SFR address |

## Verification
A wrong steering decision shows at the SFR port in the request cycle itself, either as a missing strobe or as a strobe that should not be there. A corrupted RAM byte shows up later, on the next read of that byte. Corruption across targets therefore shows only once the aliased address has been written through one mode and read back through the other. For this reason every upper address is written in both modes before any of them is read back. A latency or response-register fault shows one cycle after the request, as a missing `rsp_valid`, a stale `rsp_rdata` or a misplaced `rsp_err`.

// File: rtl/idm_pkg.sv
package idm_pkg;
  typedef enum logic [1:0] {
    TGT_LO  = 2'd0,
    TGT_UP  = 2'd1,
    TGT_SFR = 2'd2
  } idm_tgt_e;

  // Target selection: the top address bit picks the half, and the mode picks
  // between upper RAM and SFR space inside the high half.
  function automatic idm_tgt_e idm_target(input logic indirect, input logic high_half);
    if (!high_half) return TGT_LO;
    else if (indirect) return TGT_UP;
    else return TGT_SFR;
  endfunction
endpackage

// File: rtl/idm_decode.sv
module idm_decode
  import idm_pkg::*;
(
  input  logic     active,
  input  logic     indirect,
  input  logic     high_half,
  output idm_tgt_e tgt,
  output logic     lo_sel,
  output logic     up_sel,
  output logic     sfr_sel
);
  always_comb begin
    tgt     = idm_target(indirect, high_half);
    lo_sel  = active && (tgt == TGT_LO);
    up_sel  = active && (tgt == TGT_UP);
    sfr_sel = active && (tgt == TGT_SFR);
  end
endmodule

// File: rtl/idm_ram_bank.sv
module idm_ram_bank #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [IW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Contents are not reset; the read register updates on reads only.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/idm_router.sv
module idm_router
  import idm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int HALF = 2 ** (AW - 1),
  localparam int IW   = AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_indirect,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          sfr_stb,
  output logic          sfr_we,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata,
  input  logic          sfr_hit
);
  // Named internal events
  idm_tgt_e       tgt_now;
  logic           lo_sel, up_sel, sfr_sel;
  logic           req_active;
  logic [DW-1:0]  lo_rdata, up_rdata;
  logic           sfr_miss;

  assign req_active = req_valid && rst_n;

  idm_decode u_dec (
    .active    (req_active),
    .indirect  (req_indirect),
    .high_half (req_addr[AW-1]),
    .tgt       (tgt_now),
    .lo_sel    (lo_sel),
    .up_sel    (up_sel),
    .sfr_sel   (sfr_sel)
  );

  idm_ram_bank #(.DEPTH(HALF), .DW(DW)) u_lo (
    .clk   (clk),
    .en    (lo_sel),
    .we    (req_write),
    .addr  (req_addr[IW-1:0]),
    .wdata (req_wdata),
    .rdata (lo_rdata)
  );

  idm_ram_bank #(.DEPTH(HALF), .DW(DW)) u_up (
    .clk   (clk),
    .en    (up_sel),
    .we    (req_write),
    .addr  (req_addr[IW-1:0]),
    .wdata (req_wdata),
    .rdata (up_rdata)
  );

  assign sfr_stb   = sfr_sel;
  assign sfr_we    = req_write;
  assign sfr_addr  = req_addr;
  assign sfr_wdata = req_wdata;
  assign sfr_miss  = sfr_sel && !sfr_hit;

  // Response stage
  logic          rv_q, wr_q, err_q;
  idm_tgt_e      tgt_q;
  logic [DW-1:0] sfr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q  <= 1'b0;
      wr_q  <= 1'b0;
      err_q <= 1'b0;
      tgt_q <= TGT_LO;
      sfr_q <= '0;
    end else begin
      rv_q <= req_valid;
      if (req_valid) begin
        tgt_q <= tgt_now;
        wr_q  <= req_write;
        err_q <= sfr_miss;
        if (sfr_sel && !req_write) sfr_q <= sfr_rdata;
      end
    end
  end

  always_comb begin
    rsp_valid = rv_q;
    rsp_err   = rv_q && err_q;
    rsp_rdata = '0;
    if (rv_q && !wr_q && !err_q) begin
      unique case (tgt_q)
        TGT_LO:  rsp_rdata = lo_rdata;
        TGT_UP:  rsp_rdata = up_rdata;
        default: rsp_rdata = sfr_q;
      endcase
    end
  end
endmodule

// File: rtl/idm_router_checker.sv
module idm_router_checker #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          req_indirect,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_err,
  input logic          sfr_stb
);
  // R5: a response follows every request one cycle later
  a_r5_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R5: no response without a request
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R6: an error only answers a cycle that strobed the SFR port
  a_r6_err_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(sfr_stb));
  // R6: an error response carries zero data
  a_r6_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));
  // R8: write responses carry zero data
  a_r8_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == '0));
  // R2: indirect requests never reach the SFR port
  a_r2_indirect_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_indirect) |-> !sfr_stb);
  // R9: low addresses never reach the SFR port
  a_r9_low_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_addr[AW-1]) |-> !sfr_stb);
  // R7: no strobe while reset is held
  always @(posedge clk) begin
    if (!rst_n) a_r7_no_stb_in_reset: assert (!sfr_stb);
  end
endmodule

bind idm_router idm_router_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_indirect (req_indirect),
  .req_addr     (req_addr),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .rsp_err      (rsp_err),
  .sfr_stb      (sfr_stb)
);

// File: tb/idm_router_test.sv
`timescale 1ns/1ps
module idm_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, req_indirect = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic       rsp_valid, rsp_err, sfr_stb, sfr_we, sfr_hit;
  logic [7:0] rsp_rdata, sfr_addr, sfr_wdata, sfr_rdata;
  int         n_checks = 0, n_fail = 0;
  logic [7:0] sfr_model [256];

  always #2.5 clk = ~clk;

  idm_router uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_indirect(req_indirect), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .sfr_stb(sfr_stb), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit)
  );

  // Outside SFR logic: claims F0H and above as unimplemented
  assign sfr_hit   = (sfr_addr < 8'hF0);
  assign sfr_rdata = sfr_model[sfr_addr];
  always @(posedge clk) if (sfr_stb && sfr_we) sfr_model[sfr_addr] <= sfr_wdata;

  function automatic logic [7:0] pat_dir(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction
  function automatic logic [7:0] pat_ind(input logic [7:0] a);
    return (~a) + 8'd3;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge: drives one request, checks the SFR port in the
  // request cycle, then checks the response at the next falling edge.
  task automatic do_req(input logic w, input logic ind, input logic [7:0] a,
                        input logic [7:0] d, input logic [7:0] exp_rd, input logic exp_err);
    logic to_sfr;
    to_sfr = !ind && a[7];
    req_valid = 1'b1; req_write = w; req_indirect = ind; req_addr = a; req_wdata = d;
    #1;
    if (to_sfr) begin
      chk("R3 stb", sfr_stb, 1'b1);
      chk("R3 addr/we/data", {sfr_addr, sfr_we, sfr_wdata}, {a, w, d});
    end else if (ind && a[7]) chk("R2/R4 indirect no stb", sfr_stb, 1'b0);
    else chk("R9 low no stb", sfr_stb, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R5 rsp_valid", rsp_valid, 1'b1);
    chk(w ? "R8 write rdata" : "R1/R2/R3/R4 rdata", rsp_rdata, exp_rd);
    chk("R6 err", rsp_err, exp_err);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) sfr_model[i] = 8'h00;
    // R7: request held during reset must not strobe
    req_valid = 1'b1; req_addr = 8'hA0; req_indirect = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R7 no stb in reset", sfr_stb, 1'b0);
    end
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 rsp_valid after reset", rsp_valid, 1'b0);
    chk("R7 rsp_err after reset", rsp_err, 1'b0);

    // Direct writes to every address
    for (int a = 0; a < 256; a++)
      do_req(1'b1, 1'b0, 8'(a), pat_dir(8'(a)), 8'h00, (a >= 8'hF0));
    // Indirect writes to the high half (R4: must not disturb SFRs)
    for (int a = 128; a < 256; a++)
      do_req(1'b1, 1'b1, 8'(a), pat_ind(8'(a)), 8'h00, 1'b0);
    // Indirect reads of all addresses (R1 low half, R2/R4 high half)
    for (int a = 0; a < 256; a++)
      do_req(1'b0, 1'b1, 8'(a), 8'h00,
             (a < 128) ? pat_dir(8'(a)) : pat_ind(8'(a)), 1'b0);
    // Direct reads of all addresses (R1, R3, R4, R6)
    for (int a = 0; a < 256; a++)
      do_req(1'b0, 1'b0, 8'(a), 8'h00,
             (a >= 8'hF0) ? 8'h00 : pat_dir(8'(a)), (a >= 8'hF0));
    // R4: the aliased pair at A0H reads distinct values in the two modes
    do_req(1'b0, 1'b0, 8'hA0, 8'h00, 8'hFA, 1'b0);
    do_req(1'b0, 1'b1, 8'hA0, 8'h00, 8'h62, 1'b0);

    // R5: idle cycle gives no response
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R5 idle no rsp", rsp_valid, 1'b0);
    chk("R6 idle no err", rsp_err, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule